// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system use an external asynchronous static RAM of 256K words by 4 bits. On the system side there is a request/ready handshake that carries an address, write data and a direction flag, plus a strobe that marks returned read data. On the memory side it drives an 18-bit address and active-low chip-select, write-enable and output-enable strobes, and it shares a 4-bit bidirectional data bus with the memory.

Each phase length is a whole number of clocks. It is found from a nanosecond timing limit and the clock period: the limit is divided by the period, rounded up, and never less than one clock. Output enable stays high for the whole of every write, so the shorter write pulse limit applies. After every read the controller waits out the memory's output turn-off time before it can drive the data bus again, so the two sides never drive the bus at once.

Only one transaction is in flight at a time. The address and write data are captured in the cycle the request is accepted.

Top module: `asram_ctl`

## Requirements
- R1: During reset and in the first cycle after it, req_ready is 1, rd_valid is 0 and sram_cs_n, sram_we_n and sram_oe_n are all 1.
- R2: A request is taken only when req_valid and req_ready are both 1 at a clock edge. req_ready is 0 in the cycle that follows. Any req_valid seen while req_ready is 0 is ignored and writes nothing.
- R3: In a write, sram_cs_n and sram_we_n fall at the same edge and rise at the same edge. sram_oe_n stays 1 for the whole write.
- R4: After a write request, the memory holds the request's 4-bit data at the request's 18-bit address. This covers address 0x00000 and address 0x3FFFF.
- R5: In a read, sram_cs_n and sram_oe_n are low together for the access count while sram_we_n stays 1. At the edge where they rise, rd_data captures the memory word and rd_valid is 1 for exactly one cycle.
- R6: After sram_oe_n rises, at least the turnaround count of clocks (1 at defaults) passes, plus the accept cycle, before the next write lowers sram_we_n and drives data.
- R7: The controller never drives sram_dq while sram_oe_n is low.
- R8: Address and write data are captured at acceptance. Changing req_addr or req_wdata afterwards has no effect on that transaction.
- R9: Each phase count is ceil(limit / clock period), with a minimum of 1. With a 4 ns clock, the write pulse is 2 clocks (6 ns pulse, 4 ns data setup, 8 ns cycle), the read access is 2 clocks (8 ns), and the turnaround is 1 clock (4 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data is new |
| rd_data | output | 4 | Last word read |
| sram_addr | output | 18 | Memory address |
| sram_dq | inout | 4 | Shared memory data bus |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |

## Verification
Two things happen at the same edge at the end of a read. The data capture, with its rd_valid pulse, and the release of the output strobes that starts the turnaround both fall there. A write that is already waiting on req_valid then lands right behind them. The bench provokes this by issuing a write directly after each read. It then checks three things: the captured word against its own reference copy of memory, that rd_valid lasts a single cycle, and that the number of clocks between sram_oe_n rising and sram_we_n falling meets the turnaround rule.

// File: rtl/asram_ctl_pkg.sv
// Package: shared types and cycle-count arithmetic for the SRAM controller.
// Assumes timing limits and clock period are given in picoseconds.
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } ctl_state_t;

    // Clocks needed to cover a time limit: rounded up, at least one.
    function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_ctl_phase_cnt.sv
// Module: down counter that times each strobe phase.
// Loading sets the count; the counter then steps down to zero and holds there.
// Assumes that a load and a count never need to happen in the same cycle.
module asram_ctl_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/asram_ctl_dq_io.sv
// Module: tri-state buffer for the shared memory data bus.
// It drives the bus only while drive_en is high; at all other times the pad floats.
module asram_ctl_dq_io #(
    parameter int DW = 4
) (
    input  logic          drive_en,
    input  logic [DW-1:0] dout,
    output logic [DW-1:0] din,
    inout  wire  [DW-1:0] pad
);
    // Drive the pad, or release it to high impedance.
    assign pad = drive_en ? dout : {DW{1'bz}};
    // The pad is always readable.
    assign din = pad;

endmodule

// File: rtl/asram_ctl_seq.sv
// Module: strobe sequencer for the asynchronous SRAM.
// Every memory-side output comes from a register, so there are no glitches on the strobes.
// A write runs: CS+WE low with data driven, then both rise, then the bus is
// released one clock later. A read runs: CS+OE low, data captured, then a
// turnaround wait. Assumes phase counts of at least 1.
module asram_ctl_seq
    import asram_ctl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 4,
    parameter int CNT_W   = 4,
    parameter int WP_CYC  = 2,
    parameter int ACC_CYC = 2,
    parameter int TRN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    mem_addr,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe,
    output logic [DW-1:0]    dq_out,
    input  logic [DW-1:0]    dq_in,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_zero
);
    ctl_state_t state;
    logic       accept;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Choose what to load into the phase counter when a phase begins.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept) begin
            cnt_load = 1'b1;
            cnt_val  = req_write ? CNT_W'(WP_CYC - 1) : CNT_W'(ACC_CYC - 1);
        end else if (state == ST_RACC && cnt_zero) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(TRN_CYC - 1);
        end
    end

    // Main sequencer: state register, the registered strobes, bus control and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
            mem_addr <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mem_addr <= req_addr;
                        cs_n     <= 1'b0;
                        if (req_write) begin
                            we_n   <= 1'b0;
                            dq_oe  <= 1'b1;
                            dq_out <= req_wdata;
                            state  <= ST_WPULSE;
                        end else begin
                            oe_n  <= 1'b0;
                            state <= ST_RACC;
                        end
                    end
                end
                ST_WPULSE: begin
                    if (cnt_zero) begin
                        cs_n  <= 1'b1;
                        we_n  <= 1'b1;
                        state <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    dq_oe <= 1'b0;
                    state <= ST_IDLE;
                end
                ST_RACC: begin
                    if (cnt_zero) begin
                        rd_data  <= dq_in;
                        rd_valid <= 1'b1;
                        cs_n     <= 1'b1;
                        oe_n     <= 1'b1;
                        state    <= ST_RTURN;
                    end
                end
                ST_RTURN: begin
                    if (cnt_zero)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: write enable is never low without chip select.
    a_r3_we_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
    // R3: output enable stays high for the whole write.
    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    // R7: the bus is never driven while the memory outputs may be on.
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && $past(oe_n)));
    // R6: the bus stays released in the cycle after output enable rises.
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |=> !dq_oe);
    // R5: the read strobe lasts one cycle.
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R2: after an accept, the controller is busy.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/asram_ctl.sv
// Module: top of the asynchronous SRAM controller.
// Turns nanosecond timing limits into clock counts and wires together the
// sequencer, the phase counter and the data-bus buffer. Assumes one memory
// device and a synchronous active-low reset.
module asram_ctl
    import asram_ctl_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 4,
    parameter int CLK_PS   = 4000,
    parameter int T_WP_PS  = 6000,
    parameter int T_DS_PS  = 4000,
    parameter int T_AW_PS  = 6000,
    parameter int T_WC_PS  = 8000,
    parameter int T_ACC_PS = 8000,
    parameter int T_OFF_PS = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] sram_addr,
    inout  wire  [DW-1:0] sram_dq,
    output logic          sram_cs_n,
    output logic          sram_we_n,
    output logic          sram_oe_n
);
    // The write pulse must meet the pulse width, the data setup and the
    // address-to-end limits. Together with the hold clock it must also fill a write cycle.
    localparam int WC_CYC  = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int WP_CYC  = max2(max2(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DS_PS, CLK_PS)),
                                  max2(ps_to_cyc(T_AW_PS, CLK_PS), (WC_CYC > 1) ? WC_CYC - 1 : 1));
    localparam int ACC_CYC = ps_to_cyc(T_ACC_PS, CLK_PS);
    localparam int TRN_CYC = ps_to_cyc(T_OFF_PS, CLK_PS);
    localparam int MAX_CYC = max2(max2(WP_CYC, ACC_CYC), TRN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             dq_oe;
    logic [DW-1:0]    dq_out;
    logic [DW-1:0]    dq_in;

    asram_ctl_seq #(
        .AW(AW), .DW(DW), .CNT_W(CNT_W),
        .WP_CYC(WP_CYC), .ACC_CYC(ACC_CYC), .TRN_CYC(TRN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(sram_addr), .cs_n(sram_cs_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
        .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_zero(cnt_zero)
    );

    asram_ctl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    asram_ctl_dq_io #(.DW(DW)) u_io (
        .drive_en(dq_oe), .dout(dq_out), .din(dq_in), .pad(sram_dq)
    );

endmodule

// File: tb/asram_ctl_bench.sv
// Scoreboard bench: driver tasks push expected read words; a monitor pops them on rd_valid.
module asram_ctl_bench;
    localparam int WP = 2, ACC = 2, TURN = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write, rd_valid;
    logic [17:0] req_addr, sram_addr;
    logic [3:0]  req_wdata, rd_data;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    wire  [3:0]  sram_dq;

    asram_ctl u_asram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_dq(sram_dq), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n)
    );

    // Memory model: sparse store, output driven in read mode only.
    logic [3:0] model_mem [int unsigned];
    logic [3:0] ref_mem   [int unsigned];
    logic [3:0] mdl_q = 4'h0;
    logic       mdl_drv;
    assign mdl_drv = !sram_cs_n && sram_we_n && !sram_oe_n;
    assign sram_dq = mdl_drv ? mdl_q : 4'bz;

    always @(negedge clk) begin
        if (!sram_cs_n && !sram_we_n) model_mem[sram_addr] = sram_dq;
        mdl_q <= model_mem.exists(sram_addr) ? model_mem[sram_addr] : 4'h0;
    end

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [3:0] exp_q [$];
    string      tag_q [$];

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_rd(logic [17:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 4'h0;
    endfunction

    // Driver: waits for ready, presents one request, and books the expected result.
    task automatic issue(bit wr, logic [17:0] a, logic [3:0] d, string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2", req_ready, 0);
        if (wr) ref_mem[a] = d;
        else begin exp_q.push_back(ref_rd(a)); tag_q.push_back(tag); end
    endtask

    // Monitor: compare each returned word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R5", rd_data, 0);
            else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    // Strobe monitor: phase lengths, write-mode strobes and turnaround.
    int we_run = 0, oe_run = 0, since_oe = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_we_n) begin
                we_run++;
                if (we_run == 1) check(since_oe >= TURN + 1, "R6", since_oe, TURN + 1);
                check(sram_oe_n && !sram_cs_n, "R3", {sram_oe_n, sram_cs_n}, 2'b10);
            end else if (we_run != 0) begin
                check(we_run == WP && sram_cs_n, "R9", we_run, WP);
                we_run = 0;
            end
            if (!sram_oe_n) begin
                oe_run++;
                since_oe = 0;
                check(sram_we_n && !sram_cs_n, "R5", {sram_we_n, sram_cs_n}, 2'b10);
            end else begin
                if (oe_run != 0) begin
                    check(oe_run == ACC, "R9", oe_run, ACC);
                    oe_run = 0;
                end
                if (since_oe < 100) since_oe++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset.
        check(req_ready && !rd_valid && sram_cs_n && sram_we_n && sram_oe_n, "R1",
              {req_ready, rd_valid, sram_cs_n, sram_we_n, sram_oe_n}, 5'b10111);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rd_valid && sram_cs_n && sram_we_n && sram_oe_n, "R1",
              {req_ready, rd_valid, sram_cs_n, sram_we_n, sram_oe_n}, 5'b10111);

        // R4: writes at the address edges and with varied data.
        issue(1, 18'h00000, 4'h5, "R4");
        issue(1, 18'h3FFFF, 4'hA, "R4");
        issue(1, 18'h12345, 4'hF, "R4");
        issue(1, 18'h00001, 4'h0, "R4");
        issue(0, 18'h00000, 4'h0, "R4");
        issue(0, 18'h3FFFF, 4'h0, "R4");
        issue(0, 18'h12345, 4'h0, "R5");
        issue(0, 18'h00001, 4'h0, "R5");
        // R6: a write directly behind each read.
        for (int i = 0; i < 4; i++) begin
            issue(0, 18'h12345, 4'h0, "R5");
            issue(1, 18'h12345, 4'(i + 6), "R6");
        end
        issue(0, 18'h12345, 4'h0, "R6");
        issue(0, 18'h2AAAA, 4'h0, "R5");

        // R2 and R8: a request while busy is ignored, and changing inputs after the accept has no effect.
        issue(1, 18'h00100, 4'h3, "R8");
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00200; req_wdata = 4'h9;
        @(negedge clk);
        req_valid = 1'b0;
        issue(0, 18'h00100, 4'h0, "R8");
        issue(0, 18'h00200, 4'h0, "R2");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        finish_run();
    end

endmodule